// File: doc/BRIEF.md
# MAC Learning and Forwarding Lookup

This block decides where a received Ethernet frame goes and remembers where its sender lives. Each frame arrives as one descriptor: destination and source addresses, VLAN ID, the ingress port, the set of ports that belong to the frame's VLAN, and a flag saying whether the frame was received without error. The block answers with one output pulse that carries an egress port mask and a two-bit class. The class says whether the answer came from the learned table, from a flood, from a static entry, or from a group-address register.

The learned table is direct-mapped. The low bits of an address select the slot, and the slot keeps the remaining upper address bits as a tag. It also keeps the VLAN ID and the port the address was last seen on. Before the table is used, several configured registers are consulted in order: static address/mask pairs first, then the broadcast mask, then a parameterised bank of multicast address/mask pairs. The table sits behind one synchronous RAM port. The destination lookup is served first, and the learn write for the same frame follows it, so `busy` holds off the next descriptor until both have used the port.

Top module: `fwd_lookup`

## Requirements
- R1: Table slot index is address bits [IDX_W-1:0] (IDX_W = 11 by default, 15 as the wide option). A table hit needs a valid slot whose stored bits [47:11] equal the destination's bits [47:11]. A hit yields a one-hot mask of the stored port and class 1 (HIT). Addresses that share only the index bits miss.
- R2: The source address, VLAN ID and ingress port are written into the table only when the good-frame flag of that descriptor is 1.
- R3: If the destination equals any enabled static address, the mask of the lowest-numbered matching static entry is used with class 2 (STATIC), ahead of every other source.
- R4: A destination of all ones, with no static match, gives the broadcast mask and class 3 (MCAST).
- R5: A group destination (bit 40 set, not broadcast) that matches an enabled multicast register gives the mask of the lowest-numbered match and class 3.
- R6: A group destination matching no multicast register goes through the table like any other address.
- R7: A miss gives class 0 (MISS) and the flood mask. The flood mask resets to all ports except the CPU port (the highest port) and is replaced when `flood_we` is 1.
- R8: With `vlan_en` = 1, a table hit also needs the stored VLAN ID to equal the frame's, and the flood and broadcast masks are ANDed with the frame's VLAN member mask.
- R9: The ingress port bit is always 0 in the output mask, whatever the source of the mask.
- R10: The lookup reads the table before that frame's learn write, so a frame whose destination equals its own source, seen for the first time, misses.
- R11: A descriptor accepted on clock edge N (`in_valid` = 1 while `busy` = 0) raises `busy` after that edge. It produces a single-cycle `out_valid` after edge N+2, and no other output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_dmac | input | 48 | Destination address |
| in_smac | input | 48 | Source address |
| in_vid | input | 12 | Frame VLAN ID |
| in_port | input | PW | Ingress port number |
| in_good | input | 1 | Frame received without error |
| in_members | input | NPORT | Port members of the frame's VLAN |
| busy | output | 1 | Descriptor not accepted while high |
| vlan_en | input | 1 | VLAN-aware matching and flood restriction |
| st_valid | input | ST_N | Static entry enables |
| st_mac | input | ST_N x 48 | Static addresses |
| st_mask | input | ST_N x NPORT | Static port masks |
| mc_valid | input | MC_N | Multicast register enables |
| mc_mac | input | MC_N x 48 | Multicast addresses |
| mc_mask | input | MC_N x NPORT | Multicast port masks |
| bcast_mask | input | NPORT | Broadcast port mask |
| flood_we | input | 1 | Load the flood mask |
| flood_wdata | input | NPORT | New flood mask |
| out_valid | output | 1 | Result pulse |
| out_mask | output | NPORT | Egress port mask |
| out_class | output | 2 | 0 MISS, 1 HIT, 2 STATIC, 3 MCAST |

## Verification
The destination lookup and the source learn for one frame both need the single table port, and they fall in adjacent cycles. When a frame names itself as destination, the read and the write target the same slot. The bench provokes this with a frame whose destination equals its own source, followed at once by a second frame to that address. The first must miss and the second must hit. A behavioural model that applies each frame's lookup before its learn predicts both results, and the outputs are compared with it on every clock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int MAC_W   = 48;
  localparam int VID_W   = 12;
  localparam int TAG_LSB = 11;
  localparam int TAG_W   = MAC_W - TAG_LSB;
  localparam int GRP_BIT = 40;

  typedef enum logic [1:0] {
    CLS_MISS   = 2'd0,
    CLS_HIT    = 2'd1,
    CLS_STATIC = 2'd2,
    CLS_MCAST  = 2'd3
  } fwd_class_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOOK = 2'd1,
    PH_RES  = 2'd2
  } fwd_phase_e;

  function automatic logic [TAG_W-1:0] mac_tag(input logic [MAC_W-1:0] m);
    return m[MAC_W-1:TAG_LSB];
  endfunction

  function automatic logic is_group(input logic [MAC_W-1:0] m);
    return m[GRP_BIT];
  endfunction

  function automatic logic is_bcast(input logic [MAC_W-1:0] m);
    return &m;
  endfunction
endpackage

// File: rtl/fwd_addr_table.sv
module fwd_addr_table
  import fwd_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [VID_W-1:0] w_vid,
  input  logic [PW-1:0]    w_port,
  output logic             r_valid,
  output logic [TAG_W-1:0] r_tag,
  output logic [VID_W-1:0] r_vid,
  output logic [PW-1:0]    r_port
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = TAG_W + VID_W + PW;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= {w_tag, w_vid, w_port};
    if (en && !we) rd_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      r_valid <= 1'b0;
    end else if (en) begin
      if (we) vld_q[addr] <= 1'b1;
      else    r_valid     <= vld_q[addr];
    end
  end

  assign r_tag  = rd_q[ENT_W-1 -: TAG_W];
  assign r_vid  = rd_q[PW +: VID_W];
  assign r_port = rd_q[PW-1:0];
endmodule

// File: rtl/fwd_cfg_match.sv
module fwd_cfg_match
  import fwd_pkg::*;
#(
  parameter int N     = 4,
  parameter int NPORT = 8
) (
  input  logic [MAC_W-1:0]          key,
  input  logic [N-1:0]              ent_valid,
  input  logic [N-1:0][MAC_W-1:0]   ent_mac,
  input  logic [N-1:0][NPORT-1:0]   ent_mask,
  output logic                      hit,
  output logic [NPORT-1:0]          mask
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = ent_valid[i] && (ent_mac[i] == key);
  end

  always_comb begin
    mask = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) mask = ent_mask[i];
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/fwd_resolve.sv
module fwd_resolve
  import fwd_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int PW    = 3
) (
  input  logic [MAC_W-1:0] dmac,
  input  logic [VID_W-1:0] vid,
  input  logic [PW-1:0]    in_port,
  input  logic [NPORT-1:0] members,
  input  logic             vlan_en,
  input  logic             st_hit,
  input  logic [NPORT-1:0] st_mask,
  input  logic             mc_hit,
  input  logic [NPORT-1:0] mc_mask,
  input  logic [NPORT-1:0] bcast_mask,
  input  logic [NPORT-1:0] flood_mask,
  input  logic             tb_valid,
  input  logic [TAG_W-1:0] tb_tag,
  input  logic [VID_W-1:0] tb_vid,
  input  logic [PW-1:0]    tb_port,
  output logic             tbl_hit,
  output logic [NPORT-1:0] res_mask,
  output fwd_class_e       res_class
);
  function automatic logic [NPORT-1:0] port_bit(input logic [PW-1:0] p);
    logic [NPORT-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  logic [NPORT-1:0] vmask;
  logic [NPORT-1:0] pick;

  assign vmask   = vlan_en ? members : '1;
  assign tbl_hit = tb_valid && (tb_tag == mac_tag(dmac)) &&
                   (!vlan_en || (tb_vid == vid));

  always_comb begin
    if (st_hit) begin
      pick      = st_mask;
      res_class = CLS_STATIC;
    end else if (is_bcast(dmac)) begin
      pick      = bcast_mask & vmask;
      res_class = CLS_MCAST;
    end else if (is_group(dmac) && mc_hit) begin
      pick      = mc_mask;
      res_class = CLS_MCAST;
    end else if (tbl_hit) begin
      pick      = port_bit(tb_port);
      res_class = CLS_HIT;
    end else begin
      pick      = flood_mask & vmask;
      res_class = CLS_MISS;
    end
  end

  assign res_mask = pick & ~port_bit(in_port);
endmodule

// File: rtl/fwd_lookup.sv
module fwd_lookup
  import fwd_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int IDX_W = 11,
  parameter int ST_N  = 4,
  parameter int MC_N  = 8,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [47:0]                 in_dmac,
  input  logic [47:0]                 in_smac,
  input  logic [11:0]                 in_vid,
  input  logic [PW-1:0]               in_port,
  input  logic                        in_good,
  input  logic [NPORT-1:0]            in_members,
  output logic                        busy,
  input  logic                        vlan_en,
  input  logic [ST_N-1:0]             st_valid,
  input  logic [ST_N-1:0][47:0]       st_mac,
  input  logic [ST_N-1:0][NPORT-1:0]  st_mask,
  input  logic [MC_N-1:0]             mc_valid,
  input  logic [MC_N-1:0][47:0]       mc_mac,
  input  logic [MC_N-1:0][NPORT-1:0]  mc_mask,
  input  logic [NPORT-1:0]            bcast_mask,
  input  logic                        flood_we,
  input  logic [NPORT-1:0]            flood_wdata,
  output logic                        out_valid,
  output logic [NPORT-1:0]            out_mask,
  output logic [1:0]                  out_class
);
  localparam int CPU_PORT = NPORT - 1;
  localparam logic [NPORT-1:0] FLOOD_RST = ~(NPORT'(1) << CPU_PORT);

  fwd_phase_e       phase_q;
  logic [MAC_W-1:0] d_dmac, d_smac;
  logic [VID_W-1:0] d_vid;
  logic [PW-1:0]    d_port;
  logic             d_good;
  logic [NPORT-1:0] d_members;
  logic [NPORT-1:0] flood_q;

  // named events for the checker
  logic accept, look_rd, in_res, learn_we;
  logic st_hit, mc_hit, tbl_hit;
  logic [NPORT-1:0] st_sel, mc_sel, res_mask;
  fwd_class_e res_class;

  logic             tb_en;
  logic [IDX_W-1:0] tb_addr;
  logic             tb_valid;
  logic [TAG_W-1:0] tb_tag;
  logic [VID_W-1:0] tb_vid;
  logic [PW-1:0]    tb_port;

  assign busy     = (phase_q != PH_IDLE);
  assign accept   = in_valid && !busy;
  assign look_rd  = (phase_q == PH_LOOK);
  assign in_res   = (phase_q == PH_RES);
  assign learn_we = in_res && d_good;
  assign tb_en    = look_rd || learn_we;
  assign tb_addr  = learn_we ? d_smac[IDX_W-1:0] : d_dmac[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (accept) phase_q <= PH_LOOK;
        PH_LOOK: phase_q <= PH_RES;
        PH_RES:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_dmac    <= '0;
      d_smac    <= '0;
      d_vid     <= '0;
      d_port    <= '0;
      d_good    <= 1'b0;
      d_members <= '0;
    end else if (accept) begin
      d_dmac    <= in_dmac;
      d_smac    <= in_smac;
      d_vid     <= in_vid;
      d_port    <= in_port;
      d_good    <= in_good;
      d_members <= in_members;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flood_q <= FLOOD_RST;
    else if (flood_we) flood_q <= flood_wdata;
  end

  fwd_addr_table #(.IDX_W(IDX_W), .PW(PW)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tb_en),
    .we     (learn_we),
    .addr   (tb_addr),
    .w_tag  (mac_tag(d_smac)),
    .w_vid  (d_vid),
    .w_port (d_port),
    .r_valid(tb_valid),
    .r_tag  (tb_tag),
    .r_vid  (tb_vid),
    .r_port (tb_port)
  );

  fwd_cfg_match #(.N(ST_N), .NPORT(NPORT)) u_static (
    .key      (d_dmac),
    .ent_valid(st_valid),
    .ent_mac  (st_mac),
    .ent_mask (st_mask),
    .hit      (st_hit),
    .mask     (st_sel)
  );

  fwd_cfg_match #(.N(MC_N), .NPORT(NPORT)) u_mcast (
    .key      (d_dmac),
    .ent_valid(mc_valid),
    .ent_mac  (mc_mac),
    .ent_mask (mc_mask),
    .hit      (mc_hit),
    .mask     (mc_sel)
  );

  fwd_resolve #(.NPORT(NPORT), .PW(PW)) u_resolve (
    .dmac      (d_dmac),
    .vid       (d_vid),
    .in_port   (d_port),
    .members   (d_members),
    .vlan_en   (vlan_en),
    .st_hit    (st_hit),
    .st_mask   (st_sel),
    .mc_hit    (mc_hit),
    .mc_mask   (mc_sel),
    .bcast_mask(bcast_mask),
    .flood_mask(flood_q),
    .tb_valid  (tb_valid),
    .tb_tag    (tb_tag),
    .tb_vid    (tb_vid),
    .tb_port   (tb_port),
    .tbl_hit   (tbl_hit),
    .res_mask  (res_mask),
    .res_class (res_class)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_class <= CLS_MISS;
    end else begin
      out_valid <= in_res;
      if (in_res) begin
        out_mask  <= res_mask;
        out_class <= res_class;
      end
    end
  end
endmodule

// File: rtl/fwd_lookup_chk.sv
module fwd_lookup_chk
  import fwd_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int PW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             look_rd,
  input logic             in_res,
  input logic             learn_we,
  input logic             st_hit,
  input logic [PW-1:0]    d_port,
  input logic             out_valid,
  input logic [NPORT-1:0] out_mask,
  input logic [1:0]       out_class
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R11
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_res |=> out_valid); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
  AST_INGRESS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask[d_port] == 1'b0)); // R9
  AST_LEARN_AFTER_LOOK: assert property (@(posedge clk) disable iff (!rst_n)
    learn_we |-> $past(look_rd)); // R10
  AST_STATIC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_res && st_hit) |=> (out_class == CLS_STATIC)); // R3
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == CLS_HIT) |-> ($countones(out_mask) <= 1)); // R1
endmodule

bind fwd_lookup fwd_lookup_chk #(.NPORT(NPORT), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .accept   (accept),
  .busy     (busy),
  .look_rd  (look_rd),
  .in_res   (in_res),
  .learn_we (learn_we),
  .st_hit   (st_hit),
  .d_port   (d_port),
  .out_valid(out_valid),
  .out_mask (out_mask),
  .out_class(out_class)
);

// File: tb/test_fwd_lookup.sv
`timescale 1ns/1ps
module test_fwd_lookup;
  localparam int NPORT = 8;
  localparam int ST_N  = 4;
  localparam int MC_N  = 8;
  localparam int PW    = 3;
  localparam int SLOTS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                        in_valid = 1'b0;
  logic [47:0]                 in_dmac = '0, in_smac = '0;
  logic [11:0]                 in_vid = '0;
  logic [PW-1:0]               in_port = '0;
  logic                        in_good = 1'b0;
  logic [NPORT-1:0]            in_members = '0;
  logic                        busy;
  logic                        vlan_en = 1'b0;
  logic [ST_N-1:0]             st_valid = '0;
  logic [ST_N-1:0][47:0]       st_mac = '0;
  logic [ST_N-1:0][NPORT-1:0]  st_mask = '0;
  logic [MC_N-1:0]             mc_valid = '0;
  logic [MC_N-1:0][47:0]       mc_mac = '0;
  logic [MC_N-1:0][NPORT-1:0]  mc_mask = '0;
  logic [NPORT-1:0]            bcast_mask = '0;
  logic                        flood_we = 1'b0;
  logic [NPORT-1:0]            flood_wdata = '0;
  logic                        out_valid;
  logic [NPORT-1:0]            out_mask;
  logic [1:0]                  out_class;

  fwd_lookup #(.NPORT(NPORT), .IDX_W(11), .ST_N(ST_N), .MC_N(MC_N)) i_fwd_lookup (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dmac(in_dmac),
    .in_smac(in_smac), .in_vid(in_vid), .in_port(in_port), .in_good(in_good),
    .in_members(in_members), .busy(busy), .vlan_en(vlan_en),
    .st_valid(st_valid), .st_mac(st_mac), .st_mask(st_mask),
    .mc_valid(mc_valid), .mc_mac(mc_mac), .mc_mask(mc_mask),
    .bcast_mask(bcast_mask), .flood_we(flood_we), .flood_wdata(flood_wdata),
    .out_valid(out_valid), .out_mask(out_mask), .out_class(out_class)
  );

  int checks = 0, fails = 0, cyc = 0, exp_cyc = -1;
  logic [NPORT-1:0] exp_mask;
  int exp_cls;
  string exp_req = "";
  bit done = 0;

  // behavioural model state
  bit          m_used [int];
  longint      m_upper [int];
  int          m_vid [int];
  int          m_port [int];
  logic [NPORT-1:0] m_flood = 8'h7F; // all but CPU port 7

  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail_msg(input string req, input string what, input longint act, input longint expv);
    fails++;
    $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (cyc == exp_cyc) begin
        if (out_valid !== 1'b1) fail_msg(exp_req, "out_valid", out_valid, 1);
        else if (out_mask !== exp_mask) fail_msg(exp_req, "out_mask", out_mask, exp_mask);
        else if (out_class !== 2'(exp_cls)) fail_msg(exp_req, "out_class", out_class, exp_cls);
      end else if (out_valid !== 1'b0) begin
        fail_msg("R11", "stray out_valid", out_valid, 0);
      end
    end
  end

  task automatic model(input logic [47:0] da, sa, input int vid, input int port,
                       input bit good, input logic [NPORT-1:0] mem);
    logic [NPORT-1:0] vm, m;
    int cls, slot;
    bit found;
    vm = vlan_en ? mem : 8'hFF;
    found = 0;
    m = '0; cls = 0;
    for (int i = 0; i < ST_N; i++)
      if (!found && st_valid[i] && st_mac[i] == da) begin
        found = 1; m = st_mask[i]; cls = 2;
      end
    if (!found && da == 48'hFFFF_FFFF_FFFF) begin
      found = 1; m = bcast_mask & vm; cls = 3;
    end
    if (!found && da[40])
      for (int i = 0; i < MC_N; i++)
        if (!found && mc_valid[i] && mc_mac[i] == da) begin
          found = 1; m = mc_mask[i]; cls = 3;
        end
    if (!found) begin
      slot = int'(da % SLOTS);
      if (m_used.exists(slot) && m_upper[slot] == longint'(da / SLOTS) &&
          (!vlan_en || m_vid[slot] == vid)) begin
        m = '0; m[m_port[slot]] = 1'b1; cls = 1;
      end else begin
        m = m_flood & vm; cls = 0;
      end
    end
    m[port] = 1'b0;
    exp_mask = m;
    exp_cls  = cls;
    if (good) begin
      slot = int'(sa % SLOTS);
      m_used[slot]  = 1;
      m_upper[slot] = longint'(sa / SLOTS);
      m_vid[slot]   = vid;
      m_port[slot]  = port;
    end
  endtask

  task automatic send(input logic [47:0] da, sa, input int vid, input int port,
                      input bit good, input logic [NPORT-1:0] mem, input string req);
    @(negedge clk);
    in_dmac = da; in_smac = sa; in_vid = 12'(vid); in_port = PW'(port);
    in_good = good; in_members = mem; in_valid = 1'b1;
    model(da, sa, vid, port, good, mem);
    exp_req = req;
    exp_cyc = cyc + 3;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (busy !== 1'b1) fail_msg("R11", "busy after accept", busy, 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [47:0] MA  = 48'h0010_2030_4567;
  localparam logic [47:0] MA2 = 48'h0A10_2030_4567; // same low 11 bits as MA
  localparam logic [47:0] MB  = 48'h0022_3344_5566;
  localparam logic [47:0] MC  = 48'h0033_4455_6677;
  localparam logic [47:0] MD  = 48'h0044_5566_7788;
  localparam logic [47:0] ME  = 48'h0055_6677_8899;
  localparam logic [47:0] MF  = 48'h0066_7788_99AA;
  localparam logic [47:0] G1  = 48'h0100_5E00_0001;
  localparam logic [47:0] G2  = 48'h0100_5E00_0777;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0) fail_msg("R11", "busy after reset", busy, 0);
    // R7 default flood on a miss, R1 learning of MA on port 1
    send(MB, MA, 0, 1, 1, 8'hFF, "R7");
    // R1 hit on learned address
    send(MA, MB, 0, 2, 0, 8'hFF, "R1");
    // R1 shared index, different upper bits: miss
    send(MA2, MB, 0, 2, 0, 8'hFF, "R1");
    // R2 bad frame does not learn
    send(MB, MC, 0, 3, 0, 8'hFF, "R2");
    send(MC, MB, 0, 4, 0, 8'hFF, "R2");
    // R3 static entry overrides learned MA; R9 ingress bit removed
    st_valid = 4'b0110; st_mac[1] = MA; st_mask[1] = 8'h30; st_mac[2] = MA; st_mask[2] = 8'h03;
    send(MA, MB, 0, 4, 0, 8'hFF, "R3");
    st_valid = '0;
    // R4 broadcast
    bcast_mask = 8'hFF;
    send(BC, MB, 0, 0, 0, 8'hFF, "R4");
    // R5 multicast registers, lowest index wins
    mc_valid = 8'b0010_0100; mc_mac[2] = G1; mc_mask[2] = 8'h0C; mc_mac[5] = G1; mc_mask[5] = 8'h30;
    send(G1, MB, 0, 0, 0, 8'hFF, "R5");
    // R6 unmatched multicast falls to table and floods
    send(G2, MB, 0, 3, 0, 8'hFF, "R6");
    // R10 self-addressed frame misses, next frame hits
    send(MD, MD, 0, 5, 1, 8'hFF, "R10");
    send(MD, MB, 0, 6, 0, 8'hFF, "R10");
    // R9 destination on ingress port gives empty hit mask
    send(MB, MF, 0, 2, 1, 8'hFF, "R9");
    send(MF, MB, 0, 2, 0, 8'hFF, "R9");
    // R7 flood mask rewrite
    @(negedge clk); flood_we = 1'b1; flood_wdata = 8'h0F;
    @(negedge clk); flood_we = 1'b0; m_flood = 8'h0F;
    send(MC, MB, 0, 0, 0, 8'hFF, "R7");
    // R8 VLAN matching and member restriction
    vlan_en = 1'b1;
    send(MB, ME, 5, 1, 1, 8'h0B, "R8");
    send(ME, MB, 5, 3, 0, 8'h0B, "R8");
    send(ME, MB, 6, 3, 0, 8'h36, "R8");
    send(BC, MB, 6, 4, 0, 8'h36, "R8");
    vlan_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule